// File: doc/BRIEF.md
# Disk Controller Data FIFO

This block sits between the host data register and the byte serializer of a floppy-style disk controller. Every byte crosses it: command parameters from the host, sector data in either direction and result bytes back to the host. It holds up to sixteen bytes. Toward the host it offers a read/write data port, a ready flag, a direction flag and a DMA request. Toward the disk side it offers byte push and pop strobes. A phase input selects command, execution or result behaviour. Within the execution phase, a direction input selects a disk read or a disk write.

After reset the block behaves as a single-byte register. A configure strobe switches the execution phase to full sixteen-byte operation. The same strobe sets a service threshold, which decides how early the DMA request rises. The threshold lets the host tolerate a service latency of threshold × byte time − 1.5 µs. The FIFO is emptied when the execution phase begins.

If the disk side pushes into a full FIFO (overrun) or pops from an empty one (underrun), the transfer stops and a sticky error flag is set. After a write underrun, the block supplies zero bytes until the sector ends. It then pulses a request for the CRC to be appended. After a read overrun, the host still drains the bytes that are held.

Top module: `fdc_data_fifo`

## Requirements
- R1: After reset, the block is in single-byte mode and empty: rqm_o=1, dio_o=0, drq_o=0, drained_o=1, and err_o, pad_o and crc_req_o are all 0.
- R2: Without a configure operation, the execution phase holds one byte. After one accepted write, rqm_o is 0 and further host writes are dropped until the disk side pops that byte.
- R3: A configure strobe with cfg_fifo_en_i=1 makes the execution phase hold 16 bytes. The threshold cfg_thresh_i is taken as 1 to 15, and a value of 0 is treated as 1.
- R4: The command phase (phase_i=0) always works as a single-byte register paced by rqm_o, with dio_o=0. drq_o is 0 in every phase other than execution (phase_i=1).
- R5: On the first cycle of the execution phase, the FIFO is emptied and all strobes are ignored. drained_o is 1 on the next cycle.
- R6: In a disk read (dir_read_i=1), drq_o is 1 exactly when the fill level n is at least 1 and also at least cap − threshold. Here cap is 16 in full mode and 1 in single mode.
- R7: In a disk write (dir_read_i=0), drq_o is 1 exactly when the free space cap − n is at least the threshold.
- R8: A disk push into a full FIFO during a read is dropped and sets ovr_o and err_o. These flags stay set, and later disk pushes are dropped.
- R9: A disk pop from an empty FIFO during a write sets udr_o, err_o and pad_o, and host writes are then ignored. While pad_o is 1, disk_rdata_o is 0x00. When sector_end_i arrives, pad_o clears and crc_req_o is 1 for exactly the next cycle.
- R10: Any cycle in the command phase clears err_o, ovr_o, udr_o and pad_o.
- R11: After a read aborts, and in the result phase (phase_i=2), the host still reads every held byte in order. drq_o stays 1 while bytes remain. rqm_o=1 and drained_o=0 until the last byte is read.
- R12: With disk strobes paced at the byte time, a host that answers each request within threshold × byte time − 1.5 µs moves every byte intact and causes no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 2 | 0 command, 1 execution, 2 result |
| dir_read_i | input | 1 | Execution direction: 1 disk read, 0 disk write |
| cfg_we_i | input | 1 | Configure strobe |
| cfg_fifo_en_i | input | 1 | Full FIFO mode enable, taken on cfg_we_i |
| cfg_thresh_i | input | 4 | Service threshold, taken on cfg_we_i |
| host_wr_i | input | 1 | Host write to data register |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read from data register |
| host_rdata_o | output | 8 | Head byte for host reads |
| rqm_o | output | 1 | Data register ready for host access |
| dio_o | output | 1 | 1 toward host, 0 from host |
| drq_o | output | 1 | DMA request |
| disk_push_i | input | 1 | Disk side stores a byte |
| disk_wdata_i | input | 8 | Disk side byte in |
| disk_pop_i | input | 1 | Disk side takes a byte |
| disk_rdata_o | output | 8 | Head byte for disk side, 0x00 when empty or padding |
| sector_end_i | input | 1 | Last byte of sector sent |
| drained_o | output | 1 | FIFO empty |
| err_o | output | 1 | Sticky transfer error |
| ovr_o | output | 1 | Sticky overrun |
| udr_o | output | 1 | Sticky underrun |
| pad_o | output | 1 | Supplying zero fill bytes |
| crc_req_o | output | 1 | One-cycle request to append CRC |

## Verification
The request logic is swept over all sixteen threshold codes in both directions. In a read, one byte is added at a time; in a write, one byte is removed at a time. The expected request is computed from the fill level, which separates an off-by-one in the read trigger point from one in the write trigger point and exposes mishandling of the zero code. Single-byte command and execution traffic, an overrun followed by a split drain across the result phase, and a write underrun with padding each exercise a separate abort path. Two paced transfers use threshold 15 at a 4 µs byte time and threshold 8 at 8 µs, with the host answering 1.5 µs before the deadline. A wrong trigger level then shows up as corrupted data or a raised error.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;
  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } phase_e;
endpackage

// File: rtl/fdc_fifo_store.sv
module fdc_fifo_store #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr_q == AW'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/fdc_fifo_ctrl.sv
module fdc_fifo_ctrl
  import fdc_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int TW    = $clog2(DEPTH),
  localparam int CW    = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    phase_i,
  input  logic          dir_read_i,
  input  logic          cfg_we_i,
  input  logic          cfg_fifo_en_i,
  input  logic [TW-1:0] cfg_thresh_i,
  input  logic [CW-1:0] count_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic          disk_push_i,
  input  logic          disk_pop_i,
  input  logic          sector_end_i,
  output logic          flush_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          to_host_o,
  output logic          rqm_o,
  output logic          drq_o,
  output logic          ovr_o,
  output logic          udr_o,
  output logic          pad_o,
  output logic          crc_req_o
);
  logic          fifo_en_q;
  logic [TW-1:0] thr_q;
  logic [1:0]    prev_q;
  logic          ovr_q, udr_q, pad_q, crc_q;

  logic          in_cmd, in_exec, in_res, to_host, err, halt, full, empty;
  logic          push_req, pop_req, ovr_ev, udr_ev;
  logic [CW-1:0] cap, thr_eff, free;

  always_comb begin
    in_cmd   = phase_i == PH_CMD;
    in_exec  = phase_i == PH_EXEC;
    in_res   = !in_cmd && !in_exec;
    flush_o  = in_exec && prev_q != PH_EXEC;
    to_host  = in_res || (in_exec && dir_read_i);
    cap      = (fifo_en_q && in_exec) ? CW'(DEPTH) : CW'(1);
    thr_eff  = (fifo_en_q && thr_q != '0) ? CW'(thr_q) : CW'(1);
    full     = count_i >= cap;
    empty    = count_i == '0;
    free     = cap - count_i;
    err      = ovr_q || udr_q;
    halt     = in_exec && err;
    push_req = to_host ? disk_push_i : host_wr_i;
    pop_req  = to_host ? host_rd_i : disk_pop_i;
    push_o   = push_req && !full && !flush_o && !halt;
    pop_o    = pop_req && !empty && !flush_o && !pad_q;
    ovr_ev   = in_exec && dir_read_i && disk_push_i && full && !flush_o && !err;
    udr_ev   = in_exec && !dir_read_i && disk_pop_i && empty && !flush_o && !err;
    rqm_o    = to_host ? !empty : (!full && !halt);
    // read: drain everything once aborted; write: stop requesting on error
    if (!in_exec)        drq_o = 1'b0;
    else if (dir_read_i) drq_o = !empty && (err || count_i >= cap - thr_eff);
    else                 drq_o = !halt && free >= thr_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      thr_q     <= '0;
      prev_q    <= PH_CMD;
      ovr_q     <= 1'b0;
      udr_q     <= 1'b0;
      pad_q     <= 1'b0;
      crc_q     <= 1'b0;
    end else begin
      prev_q <= phase_i;
      crc_q  <= pad_q && sector_end_i && !in_cmd;
      if (cfg_we_i) begin
        fifo_en_q <= cfg_fifo_en_i;
        thr_q     <= cfg_thresh_i;
      end
      if (in_cmd) begin
        ovr_q <= 1'b0;
        udr_q <= 1'b0;
        pad_q <= 1'b0;
      end else begin
        if (ovr_ev) ovr_q <= 1'b1;
        if (udr_ev) begin
          udr_q <= 1'b1;
          pad_q <= 1'b1;
        end else if (sector_end_i) begin
          pad_q <= 1'b0;
        end
      end
    end
  end

  assign to_host_o = to_host;
  assign ovr_o     = ovr_q;
  assign udr_o     = udr_q;
  assign pad_o     = pad_q;
  assign crc_req_o = crc_q;
endmodule

// File: rtl/fdc_data_fifo.sv
module fdc_data_fifo #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int TW    = $clog2(DEPTH),
  localparam int CW    = TW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       phase_i,
  input  logic             dir_read_i,
  input  logic             cfg_we_i,
  input  logic             cfg_fifo_en_i,
  input  logic [TW-1:0]    cfg_thresh_i,
  input  logic             host_wr_i,
  input  logic [WIDTH-1:0] host_wdata_i,
  input  logic             host_rd_i,
  output logic [WIDTH-1:0] host_rdata_o,
  output logic             rqm_o,
  output logic             dio_o,
  output logic             drq_o,
  input  logic             disk_push_i,
  input  logic [WIDTH-1:0] disk_wdata_i,
  input  logic             disk_pop_i,
  output logic [WIDTH-1:0] disk_rdata_o,
  input  logic             sector_end_i,
  output logic             drained_o,
  output logic             err_o,
  output logic             ovr_o,
  output logic             udr_o,
  output logic             pad_o,
  output logic             crc_req_o
);
  logic             flush, push, pop, to_host;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] head;

  fdc_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i, .rst_ni, .phase_i, .dir_read_i,
    .cfg_we_i, .cfg_fifo_en_i, .cfg_thresh_i,
    .count_i   (count),
    .host_wr_i, .host_rd_i, .disk_push_i, .disk_pop_i, .sector_end_i,
    .flush_o   (flush),
    .push_o    (push),
    .pop_o     (pop),
    .to_host_o (to_host),
    .rqm_o, .drq_o, .ovr_o, .udr_o, .pad_o, .crc_req_o
  );

  fdc_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .push_i  (push),
    .wdata_i (to_host ? disk_wdata_i : host_wdata_i),
    .pop_i   (pop),
    .rdata_o (head),
    .count_o (count)
  );

  assign dio_o        = to_host;
  assign drained_o    = count == '0;
  assign err_o        = ovr_o || udr_o;
  assign host_rdata_o = head;
  assign disk_rdata_o = (pad_o || count == '0) ? '0 : head;
endmodule

// File: rtl/fdc_data_fifo_chk.sv
module fdc_data_fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       phase_i,
  input logic             rqm_o,
  input logic             dio_o,
  input logic             drq_o,
  input logic             err_o,
  input logic             ovr_o,
  input logic             pad_o,
  input logic             crc_req_o,
  input logic             drained_o,
  input logic [WIDTH-1:0] disk_rdata_o,
  input logic             sector_end_i
);
  logic [1:0] ph_prev_q;
  logic       pad_prev_q, end_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_prev_q  <= 2'd0;
      pad_prev_q <= 1'b0;
      end_prev_q <= 1'b0;
    end else begin
      ph_prev_q  <= phase_i;
      pad_prev_q <= pad_o;
      end_prev_q <= sector_end_i;
    end
  end

  assert_cmd_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 2'd0 |-> !dio_o && !drq_o);
  assert_no_drq_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 2'd2 |-> !drq_o);
  assert_flush_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'd1 && ph_prev_q != 2'd1) |=> drained_o);
  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && phase_i != 2'd0) |=> ovr_o);
  assert_pad_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_o |-> disk_rdata_o == '0);
  assert_crc_after_pad_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_req_o |-> pad_prev_q && end_prev_q);
  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 2'd0 |=> !err_o);
  assert_result_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'd2 && !drained_o) |-> rqm_o && dio_o);
endmodule

bind fdc_data_fifo fdc_data_fifo_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_fdc_data_fifo.sv
`timescale 1ns/1ps
module test_fdc_data_fifo;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] phase_i = 2'd0;
  logic       dir_read_i = 1'b0;
  logic       cfg_we_i = 1'b0, cfg_fifo_en_i = 1'b0;
  logic [3:0] cfg_thresh_i = 4'd0;
  logic       host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [7:0] host_wdata_i = 8'd0, host_rdata_o;
  logic       rqm_o, dio_o, drq_o;
  logic       disk_push_i = 1'b0, disk_pop_i = 1'b0;
  logic [7:0] disk_wdata_i = 8'd0, disk_rdata_o;
  logic       sector_end_i = 1'b0;
  logic       drained_o, err_o, ovr_o, udr_o, pad_o, crc_req_o;

  int n_chk = 0, n_fail = 0;
  int bad = 0, got = 0, sent = 0;

  always #2 clk_i = ~clk_i;

  fdc_data_fifo i_fdc_data_fifo (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask
  task automatic host_write(logic [7:0] d);
    host_wr_i = 1'b1; host_wdata_i = d; tick(); host_wr_i = 1'b0;
  endtask
  task automatic host_read();
    host_rd_i = 1'b1; tick(); host_rd_i = 1'b0;
  endtask
  task automatic disk_push(logic [7:0] d);
    disk_push_i = 1'b1; disk_wdata_i = d; tick(); disk_push_i = 1'b0;
  endtask
  task automatic disk_pop();
    disk_pop_i = 1'b1; tick(); disk_pop_i = 1'b0;
  endtask
  task automatic set_phase(logic [1:0] p);
    phase_i = p; tick();
  endtask
  task automatic configure(logic en, logic [3:0] t);
    cfg_we_i = 1'b1; cfg_fifo_en_i = en; cfg_thresh_i = t; tick(); cfg_we_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 rqm", rqm_o, 1); chk("R1 dio", dio_o, 0); chk("R1 drq", drq_o, 0);
    chk("R1 drained", drained_o, 1); chk("R1 err", err_o, 0);
    chk("R1 pad", pad_o, 0); chk("R1 crc", crc_req_o, 0);

    // R4 command phase single byte
    host_write(8'hA5);
    chk("R4 rqm full", rqm_o, 0); chk("R4 drained", drained_o, 0);
    host_write(8'h11);
    chk("R4 head kept", disk_rdata_o, 8'hA5); chk("R4 dio", dio_o, 0);
    disk_pop();
    chk("R4 rqm free", rqm_o, 1); chk("R4 emptied", drained_o, 1);

    // R5 flush, R2 single-byte execution write
    host_write(8'h3C);
    dir_read_i = 1'b0;
    set_phase(2'd1);
    chk("R5 flushed", drained_o, 1);
    chk("R7 single drq", drq_o, 1); chk("R2 rqm", rqm_o, 1);
    host_write(8'h5A);
    chk("R2 rqm held", rqm_o, 0); chk("R2 drq held", drq_o, 0);
    host_write(8'h77);
    chk("R2 second dropped", disk_rdata_o, 8'h5A);
    disk_pop();
    chk("R2 empty", drained_o, 1);

    // R9 underrun and padding
    disk_pop();
    chk("R9 udr", udr_o, 1); chk("R9 err", err_o, 1); chk("R9 pad", pad_o, 1);
    chk("R9 zero", disk_rdata_o, 0); chk("R9 rqm", rqm_o, 0); chk("R9 drq", drq_o, 0);
    host_write(8'h99);
    chk("R9 host ignored", drained_o, 1);
    chk("R9 crc idle", crc_req_o, 0);
    sector_end_i = 1'b1; tick(); sector_end_i = 1'b0;
    chk("R9 crc pulse", crc_req_o, 1); chk("R9 pad off", pad_o, 0);
    tick();
    chk("R9 crc single", crc_req_o, 0); chk("R9 udr sticky", udr_o, 1);

    // R10 clear
    set_phase(2'd0);
    chk("R10 err", err_o, 0); chk("R10 udr", udr_o, 0);

    // R6 + R3 read sweep over all threshold codes
    dir_read_i = 1'b1;
    for (int t = 0; t < 16; t++) begin
      configure(1'b1, 4'(t));
      set_phase(2'd1);
      for (int n = 1; n <= 16; n++) begin
        disk_push(8'(n));
        chk($sformatf("R6 t%0d n%0d", t, n), drq_o, int'(n >= 16 - ((t == 0) ? 1 : t)));
      end
      chk("R3 full rqm dio", {rqm_o, dio_o}, 3);
      chk("R3 no ovr at 16", ovr_o, 0);
      if (t != 15) set_phase(2'd0);
    end

    // R8 overrun, R11 drain split across result phase
    disk_push(8'hEE);
    chk("R8 ovr", ovr_o, 1); chk("R8 err", err_o, 1);
    disk_push(8'hEF);
    chk("R8 sticky", ovr_o, 1);
    for (int k = 1; k <= 8; k++) begin
      chk("R11 data", host_rdata_o, k); chk("R11 drq", drq_o, 1);
      host_read();
    end
    set_phase(2'd2);
    chk("R11 err kept", err_o, 1); chk("R11 rqm", rqm_o, 1);
    chk("R11 dio", dio_o, 1); chk("R4 result drq", drq_o, 0);
    for (int k = 9; k <= 16; k++) begin
      chk("R11 pending", drained_o, 0); chk("R11 rdata", host_rdata_o, k);
      host_read();
    end
    chk("R11 drained", drained_o, 1); chk("R11 rqm empty", rqm_o, 0);
    set_phase(2'd0);

    // R7 write sweep
    dir_read_i = 1'b0;
    for (int t = 0; t < 16; t++) begin
      configure(1'b1, 4'(t));
      set_phase(2'd1);
      for (int n = 0; n <= 16; n++) begin
        chk($sformatf("R7 t%0d n%0d", t, n), drq_o, int'(16 - n >= ((t == 0) ? 1 : t)));
        if (n < 16) host_write(8'(n));
      end
      chk("R3 write full", rqm_o, 0);
      set_phase(2'd0);
    end

    // R12 paced read: threshold 15, 2 Mbps (1000 cycles/byte)
    configure(1'b1, 4'd15);
    dir_read_i = 1'b1;
    set_phase(2'd1);
    bad = 0; got = 0;
    fork
      begin
        for (int k = 0; k < 40; k++) begin
          repeat (999) tick();
          disk_push(8'(k + 1));
        end
      end
      begin
        while (got < 40) begin
          while (!drq_o) tick();
          repeat (15 * 1000 - 375) tick();
          while (rqm_o && got < 40) begin
            if (host_rdata_o != 8'(got + 1)) bad++;
            got++;
            host_read();
          end
        end
      end
    join
    chk("R12 read data", bad, 0); chk("R12 read err", err_o, 0);
    set_phase(2'd0);

    // R12 paced write: threshold 8, 1 Mbps (2000 cycles/byte)
    configure(1'b1, 4'd8);
    dir_read_i = 1'b0;
    set_phase(2'd1);
    bad = 0; sent = 0;
    while (rqm_o && sent < 30) begin host_write(8'(sent + 1)); sent++; end
    fork
      begin
        for (int k = 0; k < 30; k++) begin
          repeat (1999) tick();
          if (disk_rdata_o != 8'(k + 1)) bad++;
          disk_pop();
        end
      end
      begin
        while (sent < 30) begin
          while (!drq_o) tick();
          repeat (8 * 2000 - 375) tick();
          while (rqm_o && sent < 30) begin host_write(8'(sent + 1)); sent++; end
        end
      end
    join
    chk("R12 write data", bad, 0); chk("R12 write udr", udr_o, 0);
    chk("R12 write drained", drained_o, 1);
    summary();
  end
endmodule